// File: doc/BRIEF.md
# Controller Port Register File with TH Pull-up Delay

This block is the console-side register file behind the controller connectors. It holds a read-only version byte and a data register and a direction register for each controller port. Host software reaches every register with byte or word accesses. A direction bit of 1 makes that line an output, driven from the data register. A direction bit of 0 makes the line an input, and the read-back then shows what the attached device returns. Any index that has no special meaning keeps the last byte written to it, so it can be used as scratch storage.

Undriven lines are pulled high for the peripheral, with one exception. When the TH line (bit 6) is turned from an output into an input while it was driven low, its pull-up takes effect only after a fixed number of cycles. This models the slow RC charge seen on real connectors. The block sends the value it presents on each port to the peripherals. For the first ports it also sends a one-cycle strobe each time software raises TH through the data register.

Top module: `padport_io`

## Requirements
- R1: The register index is `host_addr[4:1]`. Index 0 always reads the version byte (default 8'hA0), and a write to index 0 does not change what index 0 reads.
- R2: Every read returns the selected byte in both halves of `host_rdata`.
- R3: A read of index 1+p (ports p = 0..2) returns `(pad_in_p & ~c) | (data_p & c)`, where `c` is the direction register of port p with bit 7 forced to 1.
- R4: `pad_out` of port p carries the data bits where `c` is 1. Where `c` is 0, bits 5..0 read 1 and bit 7 reads 0.
- R5: A direction write to index 4+p that turns bit 6 from 1 to 0 while data bit 6 of port p is 0 holds `pad_out` bit 6 of that port at 0 for 25 cycles after the write edge. After that, bit 6 reads 1.
- R6: The same direction change with data bit 6 at 1 starts no delay, and `pad_out` bit 6 reads 1 in the cycle right after the write.
- R7: A byte write (`host_word`=0) is accepted only when `host_addr[0]`=1. A word write (`host_word`=1) stores `host_wdata[7:0]` at any address.
- R8: The direction registers (indices 4..6) and the spare indices 7..15 read back the last byte written to them.
- R9: `th_rise[p]` (p = 0,1) is high for exactly the one cycle after a write to index 1+p that turns data bit 6 from 0 to 1. A write that leaves bit 6 at 1, or a write to index 3, gives no strobe.
- R10: After reset, all data and direction registers read 0, no TH delay is running (so `pad_out` is 8'h7F on each port), and `th_rise` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host access this cycle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_word | input | 1 | 1 = word access, 0 = byte access |
| host_addr | input | 5 | Byte address; bits 4..1 select the register |
| host_wdata | input | 16 | Write data; only the low byte is stored |
| host_rdata | output | 16 | Selected byte, duplicated in both halves |
| pad_in | input | 24 | Lines returned by the devices, 8 bits per port |
| pad_out | output | 24 | Value presented to the devices, 8 bits per port |
| th_rise | output | 2 | TH rising strobes for ports 0 and 1 |

## Verification
The assertions take these things for granted: `host_*` inputs are stable and known at every rising edge, `rst_n` is held low for at least one edge before release, and an access lasts exactly one cycle, so a write is seen once. `pad_in` may take any value, because no property depends on it. The stimulus changes inputs 1 ns after a rising edge and samples results on the falling edge. Each write drops `host_en` right after its edge, so the delay counter and the strobe are each started by a single write.

// File: rtl/padport_pkg.sv
package padport_pkg;
  typedef logic [7:0] pbyte_t;

  localparam int     TH_BIT     = 6;
  localparam pbyte_t DIR_FORCE  = 8'h80;
  localparam pbyte_t PULL_FAST  = 8'h3F;
endpackage

// File: rtl/padport_regfile.sv
module padport_regfile
  import padport_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int NPORTS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  pbyte_t                     wr_byte,
  input  logic [IDX_W-1:0]           rd_idx,
  output pbyte_t                     rd_byte,
  output logic [NPORTS-1:0][7:0]     port_data,
  output logic [NPORTS-1:0][7:0]     port_ctrl
);
  localparam int NREG      = 1 << IDX_W;
  localparam int DATA_BASE = 1;
  localparam int CTRL_BASE = 1 + NPORTS;

  pbyte_t mem_q [NREG];
  pbyte_t mem_d [NREG];

  // next state
  always_comb begin
    for (int i = 0; i < NREG; i++) mem_d[i] = mem_q[i];
    if (wr_en) mem_d[wr_idx] = wr_byte;
  end

  // state register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rd_byte = mem_q[rd_idx];

  for (genvar p = 0; p < NPORTS; p++) begin : g_tap
    assign port_data[p] = mem_q[DATA_BASE + p];
    assign port_ctrl[p] = mem_q[CTRL_BASE + p];
  end
endmodule

// File: rtl/padport_th_timer.sv
module padport_th_timer #(
  parameter int LATENCY = 25,
  parameter int CNT_W   = $clog2(LATENCY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  output logic ready
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = arm || (cnt_q != '0);
    if (arm) cnt_d = CNT_W'(LATENCY);
    else     cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/padport_merge.sv
module padport_merge
  import padport_pkg::*;
(
  input  pbyte_t data,
  input  pbyte_t ctrl,
  input  pbyte_t dev_in,
  input  logic   th_ready,
  output pbyte_t drive,
  output pbyte_t rd_val
);
  pbyte_t dir_eff;
  pbyte_t pull;

  always_comb begin
    dir_eff      = ctrl | DIR_FORCE;
    pull         = PULL_FAST;
    pull[TH_BIT] = th_ready;
    drive        = (data & dir_eff) | (pull & ~dir_eff);
    rd_val       = (dev_in & ~dir_eff) | (data & dir_eff);
  end
endmodule

// File: rtl/padport_io.sv
module padport_io
  import padport_pkg::*;
#(
  parameter int          IDX_W        = 4,
  parameter int          NPORTS       = 3,
  parameter int          STROBE_PORTS = 2,
  parameter int          TH_LATENCY   = 25,
  parameter logic [7:0]  VERSION      = 8'hA0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_en,
  input  logic                  host_we,
  input  logic                  host_word,
  input  logic [IDX_W:0]        host_addr,
  input  logic [15:0]           host_wdata,
  output logic [15:0]           host_rdata,
  input  logic [NPORTS*8-1:0]   pad_in,
  output logic [NPORTS*8-1:0]   pad_out,
  output logic [STROBE_PORTS-1:0] th_rise
);
  localparam int CNT_W     = $clog2(TH_LATENCY + 1);
  localparam int DATA_BASE = 1;
  localparam int CTRL_BASE = 1 + NPORTS;

  logic [IDX_W-1:0]         acc_idx;
  logic                     wr_fire;
  pbyte_t                   wr_byte;
  logic [7:0]               unused_wdata_hi;
  pbyte_t                   store_rd;
  pbyte_t                   rd_byte;
  logic [NPORTS-1:0][7:0]   port_data;
  logic [NPORTS-1:0][7:0]   port_ctrl;
  logic [NPORTS-1:0][7:0]   port_rd;
  logic [NPORTS-1:0]        th_ready;

  // access decode: odd byte lane for byte writes, low byte for word writes
  assign acc_idx         = host_addr[IDX_W:1];
  assign wr_fire         = host_en && host_we && (host_word || host_addr[0]);
  assign wr_byte         = host_wdata[7:0];
  assign unused_wdata_hi = host_wdata[15:8];

  padport_regfile #(.IDX_W(IDX_W), .NPORTS(NPORTS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_fire),
    .wr_idx    (acc_idx),
    .wr_byte   (wr_byte),
    .rd_idx    (acc_idx),
    .rd_byte   (store_rd),
    .port_data (port_data),
    .port_ctrl (port_ctrl)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_BASE + p);
    localparam logic [IDX_W-1:0] CTRL_IDX = IDX_W'(CTRL_BASE + p);

    logic arm;
    // TH turned to input while it was driven low
    assign arm = wr_fire && (acc_idx == CTRL_IDX) &&
                 port_ctrl[p][TH_BIT] && !wr_byte[TH_BIT] &&
                 !port_data[p][TH_BIT];

    padport_th_timer #(.LATENCY(TH_LATENCY), .CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .arm   (arm),
      .ready (th_ready[p])
    );

    padport_merge u_merge (
      .data     (port_data[p]),
      .ctrl     (port_ctrl[p]),
      .dev_in   (pad_in[p*8 +: 8]),
      .th_ready (th_ready[p]),
      .drive    (pad_out[p*8 +: 8]),
      .rd_val   (port_rd[p])
    );

    if (p < STROBE_PORTS) begin : g_strobe
      logic rise_d, rise_q;
      assign rise_d = wr_fire && (acc_idx == DATA_IDX) &&
                      !port_data[p][TH_BIT] && wr_byte[TH_BIT];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= 1'b0;
        else        rise_q <= rise_d;
      end
      assign th_rise[p] = rise_q;
    end
  end

  // read mux: version, merged port reads, else plain storage
  always_comb begin
    rd_byte = store_rd;
    if (acc_idx == '0) rd_byte = VERSION;
    for (int p = 0; p < NPORTS; p++) begin
      if (acc_idx == IDX_W'(DATA_BASE + p)) rd_byte = port_rd[p];
    end
  end

  assign host_rdata = {rd_byte, rd_byte};
endmodule

// File: rtl/padport_io_checker.sv
module padport_io_checker #(
  parameter int         IDX_W        = 4,
  parameter int         NPORTS       = 3,
  parameter int         STROBE_PORTS = 2,
  parameter logic [7:0] VERSION      = 8'hA0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      host_en,
  input logic                      host_we,
  input logic                      host_word,
  input logic [IDX_W:0]            host_addr,
  input logic [15:0]               host_wdata,
  input logic [15:0]               host_rdata,
  input logic [NPORTS*8-1:0]       pad_out,
  input logic [STROBE_PORTS-1:0]   th_rise,
  input logic [NPORTS-1:0][7:0]    port_data,
  input logic [NPORTS-1:0][7:0]    port_ctrl
);
  logic [IDX_W-1:0] idx;
  logic             wr_ok;
  assign idx   = host_addr[IDX_W:1];
  assign wr_ok = host_en && host_we && (host_word || host_addr[0]);

  assert_version_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && !host_we && idx == '0) |-> host_rdata[7:0] == VERSION);

  assert_even_byte_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_en && host_we && !host_word && !host_addr[0]) |=>
      ($stable(port_data) && $stable(port_ctrl)));

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (th_rise == '0 && port_data == '0 && port_ctrl == '0));

  for (genvar p = 0; p < NPORTS; p++) begin : g_chk
    logic [7:0] c;
    assign c = port_ctrl[p] | 8'h80;

    assert_pullup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out[p*8 +: 8] & ~c & 8'h3F) == (~c & 8'h3F)) && !pad_out[p*8+7] == !port_data[p][7]);

    assert_th_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && idx == IDX_W'(1 + NPORTS + p) && port_ctrl[p][6] &&
       !host_wdata[6] && !port_data[p][6]) |=> !pad_out[p*8+6]);

    if (p < STROBE_PORTS) begin : g_str
      assert_strobe_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        th_rise[p] |-> $past(wr_ok && idx == IDX_W'(1 + p) && host_wdata[6]));
    end
  end
endmodule

bind padport_io padport_io_checker #(
  .IDX_W(IDX_W), .NPORTS(NPORTS), .STROBE_PORTS(STROBE_PORTS), .VERSION(VERSION)
) u_padport_io_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_en    (host_en),
  .host_we    (host_we),
  .host_word  (host_word),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .pad_out    (pad_out),
  .th_rise    (th_rise),
  .port_data  (port_data),
  .port_ctrl  (port_ctrl)
);

// File: tb/padport_io_bench.sv
`timescale 1ns/1ps
module padport_io_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_en, host_we, host_word;
  logic [4:0]  host_addr;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic [23:0] pad_in;
  logic [23:0] pad_out;
  logic [1:0]  th_rise;
  logic [7:0]  drv [3];
  logic [2:0]  loop_en;

  always #2.5 clk = ~clk;

  for (genvar p = 0; p < 3; p++) begin : g_dev
    assign pad_in[p*8 +: 8] = loop_en[p] ? pad_out[p*8 +: 8] : drv[p];
  end

  padport_io u_padport_io (
    .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_we(host_we),
    .host_word(host_word), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .pad_in(pad_in), .pad_out(pad_out), .th_rise(th_rise)
  );

  typedef struct {
    int          kind;   // 0 rdata, 1 pad_out byte, 2 strobes
    int          port;
    logic [15:0] val;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t cur;
  int   n_tests = 0;
  int   n_fail  = 0;
  bit   done    = 0;
  logic [15:0] act;

  // monitor: drains expectations on the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      cur = exp_q.pop_front();
      case (cur.kind)
        0:       act = host_rdata;
        1:       act = {8'h00, pad_out[cur.port*8 +: 8]};
        default: act = {14'h0, th_rise};
      endcase
      n_tests++;
      if (act !== cur.val) begin
        n_fail++;
        $display("FAIL %s actual=%h expected=%h", cur.tag, act, cur.val);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push_now(input int kind, input int port, input logic [15:0] v, input string tag);
    exp_t e;
    e.kind = kind; e.port = port; e.val = v; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [4:0] a, input bit word, input logic [15:0] d);
    tick();
    host_en = 1; host_we = 1; host_word = word; host_addr = a; host_wdata = d;
    tick();
    host_en = 0; host_we = 0; host_word = 0;
  endtask

  task automatic wrb(input logic [3:0] idx, input logic [7:0] d);
    wr({idx, 1'b1}, 1'b0, {8'h00, d});
  endtask

  task automatic wr_strobe(input logic [3:0] idx, input logic [7:0] d, input logic [1:0] e, input string tag);
    wrb(idx, d);
    push_now(2, 0, {14'h0, e}, tag);
  endtask

  task automatic rd_chk(input logic [3:0] idx, input logic [15:0] e, input string tag);
    tick();
    host_en = 1; host_we = 0; host_word = 0; host_addr = {idx, 1'b1};
    push_now(0, 0, e, tag);
    host_en = 0;
  endtask

  task automatic pad_chk(input int p, input logic [7:0] e, input string tag);
    tick();
    push_now(1, p, {8'h00, e}, tag);
  endtask

  task automatic strobe_chk(input logic [1:0] e, input string tag);
    tick();
    push_now(2, 0, {14'h0, e}, tag);
  endtask

  initial begin
    rst_n = 0; host_en = 0; host_we = 0; host_word = 0; host_addr = '0; host_wdata = '0;
    drv[0] = 8'hA5; drv[1] = 8'h00; drv[2] = 8'h00; loop_en = 3'b000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R10 reset state
    rd_chk(4'd4, 16'h0000, "R10 ctrl0 after reset");
    pad_chk(0, 8'h7F, "R10 pad_out after reset");
    strobe_chk(2'b00, "R10 no strobe after reset");
    rd_chk(4'd1, 16'h2525, "R10 R3 port0 read after reset");

    // R1 version, R2 duplication
    rd_chk(4'd0, 16'hA0A0, "R1 R2 version read");
    wrb(4'd0, 8'h33);
    rd_chk(4'd0, 16'hA0A0, "R1 write to index 0 no effect");

    // R3 merge, R9 strobe, R4 drive
    wrb(4'd4, 8'h0F);
    wr_strobe(4'd1, 8'hF3, 2'b01, "R9 port0 TH rise");
    strobe_chk(2'b00, "R9 strobe one cycle");
    rd_chk(4'd1, 16'hA3A3, "R3 mixed direction read");
    pad_chk(0, 8'hF3, "R4 drive with outputs");

    // R6 no delay when TH data high
    wrb(4'd4, 8'h40);
    wrb(4'd4, 8'h00);
    pad_chk(0, 8'hFF, "R6 TH high at once");
    rd_chk(4'd1, 16'hA5A5, "R3 all inputs read");

    // R9 further cases
    wr_strobe(4'd1, 8'hF3, 2'b00, "R9 TH stays high no strobe");
    wr_strobe(4'd2, 8'h40, 2'b10, "R9 port1 TH rise");
    wr_strobe(4'd3, 8'h40, 2'b00, "R9 port2 has no strobe");

    // R5 TH delay on port 2 with loopback device
    loop_en[2] = 1'b1;
    wrb(4'd3, 8'h00);
    wrb(4'd6, 8'h40);
    pad_chk(2, 8'h3F, "R4 TH driven low");
    wrb(4'd6, 8'h00);
    for (int j = 1; j <= 26; j++) begin
      if (j == 2)        rd_chk(4'd3, 16'h3F3F, "R5 TH reads low during delay");
      else if (j == 26)  rd_chk(4'd3, 16'h7F7F, "R5 TH reads high after delay");
      else if (j <= 24)  pad_chk(2, 8'h3F, "R5 TH held low");
      else               pad_chk(2, 8'h7F, "R5 TH released");
    end

    // R7 byte lane and word writes, R8 storage
    wr({4'd8, 1'b0}, 1'b0, 16'h0011);
    rd_chk(4'd8, 16'h0000, "R7 even byte write ignored");
    wr({4'd9, 1'b0}, 1'b1, 16'hBEEF);
    rd_chk(4'd9, 16'hEFEF, "R7 word write low byte");
    wrb(4'd8, 8'h5A);
    rd_chk(4'd8, 16'h5A5A, "R8 spare index storage");
    wrb(4'd15, 8'hC3);
    rd_chk(4'd15, 16'hC3C3, "R8 top index storage");
    wrb(4'd5, 8'h21);
    rd_chk(4'd5, 16'h2121, "R8 ctrl readback");
    pad_chk(1, 8'h5E, "R4 port1 partial outputs");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule